// File: doc/BRIEF.md
# Steering Phase-Frequency Comparator

This block compares the rising edges of a sensed feedback square wave with those of a reference square wave. It drives a three-level correction command for a motor speed loop. The command is coded on two wires: `up_o` asks for more drive, `down_o` asks for less, and both low means the mid, high-impedance level. While the two inputs run at different rates, the command saturates toward the faster input, so the loop starts up and pulls in at full effort. Once the rates match, the command becomes a pulse each period whose width equals the edge offset. `lock_o` reports that only a phase error remains.

Both inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer and a rising-edge detector before it reaches a ten-state machine. The states are listed below, with the edges that move between them. `+e` is a feedback rising edge alone, and `-e` is a reference rising edge alone. When both edges arrive in the same cycle, they cancel.

| State | Command | Lock | on +e | on -e |
|---|---|---|---|---|
| PH_POS_IDLE | mid | 1 | PH_LEAD | PH_LAG |
| PH_LEAD | up | 1 | FQ_UP_A | PH_POS_IDLE |
| FQ_UP_A | up | 0 | FQ_UP_B | XC_UP |
| FQ_UP_B | up | 0 | FQ_UP_B | FQ_UP_A |
| XC_UP | up | 0 | FQ_UP_A | PH_POS_IDLE |
| PH_NEG_IDLE | mid | 1 | PH_LEAD | PH_LAG |
| PH_LAG | down | 1 | PH_NEG_IDLE | FQ_DN_A |
| FQ_DN_A | down | 0 | XC_DN | FQ_DN_B |
| FQ_DN_B | down | 0 | FQ_DN_A | FQ_DN_B |
| XC_DN | down | 0 | PH_NEG_IDLE | FQ_DN_A |

Top module: `pfd_steer_top`

## Requirements
- R1: A synchronous active-high reset puts the machine in PH_POS_IDLE. In the first cycle after reset, the outputs are up_o=0, down_o=0 and lock_o=1.
- R2: Only a rising edge of an input moves the machine. A falling edge leaves the outputs unchanged.
- R3: The command is coded as up_o=1 for high, down_o=1 for low, and both 0 for mid. up_o and down_o are never both 1.
- R4: When the feedback input runs faster than the reference, up_o stays at 1 and lock_o stays at 0 once the machine has settled.
- R5: When the reference input runs faster than the feedback, down_o stays at 1 and lock_o stays at 0 once the machine has settled.
- R6: At equal rates with the feedback leading by D clock cycles, up_o is 1 for exactly D cycles in each period. down_o stays at 0 and lock_o stays at 1.
- R7: At equal rates with the feedback lagging by D clock cycles, down_o is 1 for exactly D cycles in each period. up_o stays at 0 and lock_o stays at 1.
- R8: Rising edges on both inputs in the same clock cycle cancel. At equal rates and zero offset, the output stays at mid and lock_o stays at 1.
- R9: A second unanswered rising edge on one input moves the machine past the ±2π phase range into frequency error, which drops lock_o. Further unanswered edges on the same input keep the command saturated.
- R10: Leaving frequency error takes three opposing edges. The first two keep the command saturated with lock_o at 0 (the second one enters the crossing state). The third returns the machine to a mid-level phase state with lock_o at 1.
- R11: An input that rises between two clock edges changes the command at the third clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fb_i | input | 1 | Sensed feedback square wave (positive input), asynchronous |
| ref_i | input | 1 | Reference square wave (negative input), asynchronous |
| up_o | output | 1 | Command high (full positive drive) |
| down_o | output | 1 | Command low (full negative drive) |
| lock_o | output | 1 | Only a phase error remains |

## Verification
The bench applies periodic square waves with a faster feedback, with a faster reference, and with equal rates at a fixed lead, a fixed lag and zero offset. These patterns separate saturation (R4, R5) from proportional pulse width (R6, R7) and from edge cancellation (R8). Hand-placed single pulses then walk the machine one edge at a time. They cover entry into frequency error, saturation and the three-edge recovery back into lock (R9, R10), in both directions. They also show that falling edges are ignored (R2) and that the command changes at the third clock edge (R11).

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [3:0] {
        PH_POS_IDLE = 4'd0,
        PH_LEAD     = 4'd1,
        FQ_UP_A     = 4'd2,
        FQ_UP_B     = 4'd3,
        XC_UP       = 4'd4,
        PH_NEG_IDLE = 4'd5,
        PH_LAG      = 4'd6,
        FQ_DN_A     = 4'd7,
        FQ_DN_B     = 4'd8,
        XC_DN       = 4'd9
    } pfd_state_e;

    typedef struct packed {
        logic up;
        logic down;
        logic lock;
    } pfd_cmd_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_i};
        end
    end

    // Rising edge: the newest synchronized sample is high and the one before it is low.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R2: a detected rising edge lasts a single cycle
    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic pos_edge_i,
    input  logic neg_edge_i,
    output logic up_o,
    output logic down_o,
    output logic lock_o
);
    pfd_state_e state_q, state_d;
    pfd_cmd_t   cmd;

    logic step_pos, step_neg;
    assign step_pos = pos_edge_i & ~neg_edge_i;
    assign step_neg = neg_edge_i & ~pos_edge_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_POS_IDLE: if (step_pos) state_d = PH_LEAD;     else if (step_neg) state_d = PH_LAG;
            PH_LEAD:     if (step_pos) state_d = FQ_UP_A;     else if (step_neg) state_d = PH_POS_IDLE;
            FQ_UP_A:     if (step_pos) state_d = FQ_UP_B;     else if (step_neg) state_d = XC_UP;
            FQ_UP_B:     if (step_neg) state_d = FQ_UP_A;
            XC_UP:       if (step_pos) state_d = FQ_UP_A;     else if (step_neg) state_d = PH_POS_IDLE;
            PH_NEG_IDLE: if (step_pos) state_d = PH_LEAD;     else if (step_neg) state_d = PH_LAG;
            PH_LAG:      if (step_pos) state_d = PH_NEG_IDLE; else if (step_neg) state_d = FQ_DN_A;
            FQ_DN_A:     if (step_pos) state_d = XC_DN;       else if (step_neg) state_d = FQ_DN_B;
            FQ_DN_B:     if (step_pos) state_d = FQ_DN_A;
            XC_DN:       if (step_pos) state_d = PH_NEG_IDLE; else if (step_neg) state_d = FQ_DN_A;
            default:     state_d = PH_POS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= PH_POS_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_POS_IDLE, PH_NEG_IDLE:   cmd = '{up: 1'b0, down: 1'b0, lock: 1'b1};
            PH_LEAD:                    cmd = '{up: 1'b1, down: 1'b0, lock: 1'b1};
            PH_LAG:                     cmd = '{up: 1'b0, down: 1'b1, lock: 1'b1};
            FQ_UP_A, FQ_UP_B, XC_UP:    cmd = '{up: 1'b1, down: 1'b0, lock: 1'b0};
            FQ_DN_A, FQ_DN_B, XC_DN:    cmd = '{up: 1'b0, down: 1'b1, lock: 1'b0};
            default:                    cmd = '{up: 1'b0, down: 1'b0, lock: 1'b1};
        endcase
    end

    assign up_o   = cmd.up;
    assign down_o = cmd.down;
    assign lock_o = cmd.lock;

    assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (lock_o && !up_o && !down_o));

    assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(up_o && down_o));

    assert_coincident_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_edge_i && neg_edge_i) |=> $stable(state_q));

    assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == FQ_UP_B && step_pos) |=> (state_q == FQ_UP_B));

    assert_lock_entry_mid_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> (!up_o && !down_o));

endmodule

// File: rtl/pfd_steer_top.sv
module pfd_steer_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fb_i,
    input  logic ref_i,
    output logic up_o,
    output logic down_o,
    output logic lock_o
);
    logic fb_rise, ref_rise;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) fb_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(fb_i), .rise_o(fb_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) ref_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(ref_i), .rise_o(ref_rise)
    );

    pfd_fsm fsm_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .pos_edge_i(fb_rise), .neg_edge_i(ref_rise),
        .up_o(up_o), .down_o(down_o), .lock_o(lock_o)
    );

endmodule

// File: tb/pfd_steer_top_tb_top.sv
`timescale 1ns/1ps
module pfd_steer_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fb = 1'b0, rf = 1'b0;
    logic up, dn, lk;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    pfd_steer_top dut_i (
        .clk_i(clk), .rst_i(rst), .fb_i(fb), .ref_i(rf),
        .up_o(up), .down_o(dn), .lock_o(lk)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        fb = 1'b0; rf = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // One cycle per iteration: sample at negedge, then drive the next values.
    task automatic run_wave(input int pf, input int pr, input int of, input int orr,
                            input int ncyc, input int win,
                            output int nup, output int ndn, output int nlk, output int nboth);
        nup = 0; ndn = 0; nlk = 0; nboth = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (c >= ncyc - win) begin
                nup += int'(up); ndn += int'(dn); nlk += int'(lk); nboth += int'(up & dn);
            end
            fb = ((c + of) % pf) < (pf / 2);
            rf = ((c + orr) % pr) < (pr / 2);
        end
    endtask

    // Rise, hold, fall, settle: the state has updated before the task returns.
    task automatic pulse(input bit on_fb);
        @(negedge clk);
        if (on_fb) fb = 1'b1; else rf = 1'b1;
        repeat (5) @(negedge clk);
        if (on_fb) fb = 1'b0; else rf = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(lk && !up && !dn, "R1 reset outputs", {up, dn, lk}, 3'b001);
    endtask

    task automatic t_fast_fb();
        int a, b, c, d;
        do_reset();
        run_wave(20, 30, 0, 0, 600, 300, a, b, c, d);
        check(a == 300, "R4 up saturated", a, 300);
        check(c == 0, "R4 lock low", c, 0);
        check(d == 0, "R3 no overlap", d, 0);
    endtask

    task automatic t_fast_ref();
        int a, b, c, d;
        do_reset();
        run_wave(30, 20, 0, 0, 600, 300, a, b, c, d);
        check(b == 300, "R5 down saturated", b, 300);
        check(c == 0, "R5 lock low", c, 0);
        check(d == 0, "R3 no overlap", d, 0);
    endtask

    task automatic t_lead();
        int a, b, c, d;
        do_reset();
        run_wave(40, 40, 0, 33, 400, 200, a, b, c, d);
        check(a == 35, "R6 lead width 7x5", a, 35);
        check(b == 0, "R6 no down", b, 0);
        check(c == 200, "R6 lock held", c, 200);
    endtask

    task automatic t_lag();
        int a, b, c, d;
        do_reset();
        run_wave(40, 40, 31, 0, 400, 200, a, b, c, d);
        check(b == 45, "R7 lag width 9x5", b, 45);
        check(a == 0, "R7 no up", a, 0);
        check(c == 200, "R7 lock held", c, 200);
    endtask

    task automatic t_coincident();
        int a, b, c, d;
        do_reset();
        run_wave(40, 40, 0, 0, 400, 400, a, b, c, d);
        check(a + b == 0, "R8 mid held", a + b, 0);
        check(c == 400, "R8 lock held", c, 400);
    endtask

    task automatic t_latency();
        do_reset();
        @(negedge clk); fb = 1'b1;
        @(negedge clk); check(!up, "R11 not after 1 edge", up, 0);
        @(negedge clk); check(!up, "R11 not after 2 edges", up, 0);
        @(negedge clk); check(up, "R11 up after 3 edges", up, 1);
        fb = 1'b0;
        repeat (5) @(negedge clk);
        check(up && lk, "R2 fall ignored", {up, lk}, 2'b11);
    endtask

    task automatic t_recover_up();
        do_reset();
        pulse(1'b1); check(up && lk, "R9 lead wait locked", {up, lk}, 2'b11);
        pulse(1'b1); check(up && !lk, "R9 enter freq up", {up, lk}, 2'b10);
        pulse(1'b1); pulse(1'b1);
        check(up && !lk, "R9 saturate up", {up, lk}, 2'b10);
        pulse(1'b0); check(up && !lk, "R10 first ref edge", {up, lk}, 2'b10);
        pulse(1'b0); check(up && !lk, "R10 crossing up", {up, lk}, 2'b10);
        pulse(1'b0); check(!up && !dn && lk, "R10 relock mid", {up, dn, lk}, 3'b001);
        pulse(1'b1); check(up && lk, "R10 phase lead after relock", {up, lk}, 2'b11);
    endtask

    task automatic t_recover_dn();
        do_reset();
        pulse(1'b0); check(dn && lk, "R9 lag wait locked", {dn, lk}, 2'b11);
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        check(dn && !lk, "R9 saturate down", {dn, lk}, 2'b10);
        pulse(1'b1); check(dn && !lk, "R10 first fb edge", {dn, lk}, 2'b10);
        pulse(1'b1); check(dn && !lk, "R10 crossing down", {dn, lk}, 2'b10);
        pulse(1'b1); check(!up && !dn && lk, "R10 relock mid neg", {up, dn, lk}, 3'b001);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_fast_fb();
        t_fast_ref();
        t_lead();
        t_lag();
        t_coincident();
        t_latency();
        t_recover_up();
        t_recover_dn();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule